// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home-side coherence engine for a group of memory blocks in a distributed shared-memory machine. For each block it keeps one presence flag per processor node and a single dirty flag. Nodes send read or read-exclusive requests. The controller answers from its local memory when it can. It sends invalidations or recalls only to the nodes whose presence flags are set, and it collects their acknowledgements or data-carrying revisions. It then grants the request and rewrites the directory entry.

A recall gets the current data back from the owner. The controller writes that data into memory and forwards it to the requester. A read-exclusive first removes every other copy and counts one acknowledgement per removed copy. Only then is ownership granted. The controller handles one transaction at a time. While a transaction is open, the request port is not ready, so any request to any block waits.

Top module: `fmdir_top`

## Requirements
- R1: After reset, every directory entry is empty (no presence, not dirty). The memory word of block b holds (3*b+1) truncated to the data width. The request port is ready, and no response or command is valid.
- R2: A read to a clean block is answered with that block's memory word and rsp_excl=0. No command is sent, and the requester is recorded as a sharer.
- R3: A read by node i to a block dirty at another node sends exactly one command, kind 1 (recall, keep shared), to the owner. The response waits for the owner's revision (ack_rev=1). It carries the revision data, which is also written to memory. Afterwards the block is clean and both the owner and node i are sharers.
- R4: A read-exclusive by node i to a clean block sends one command, kind 0 (invalidate), to each sharer other than i, in ascending node order. No command goes to any other node.
- R5: The grant (rsp_excl=1) for a read-exclusive is not issued until as many acknowledgements as commands sent have been accepted.
- R6: A read-exclusive to a clean block with no sharers other than the requester is granted with no command sent.
- R7: After a read-exclusive completes, the requester is the only sharer and the block is dirty. A later read by another node recalls from that requester alone.
- R8: A read-exclusive to a block dirty at another node sends one command, kind 2 (recall and invalidate), to the owner. It grants with the revision data, which is also written to memory.
- R9: While a transaction is open, req_ready is low. A request held valid during that time is served after the open transaction's response.
- R10: A request from the current owner of a dirty block is answered at once with memory data and rsp_excl=1. No command is sent and the entry is left unchanged.
- R11: A valid response or command holds its content until it is accepted.

Command kinds on cmd_kind: 0 invalidate, 1 recall to shared, 2 recall and invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_node | input | NID_W | Requesting node ID |
| req_blk | input | BLK_W | Block index |
| req_excl | input | 1 | 1 = read-exclusive, 0 = read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_node | output | NID_W | Destination node of the response |
| rsp_data | output | DATA_W | Block data |
| rsp_excl | output | 1 | 1 = ownership granted |
| cmd_valid | output | 1 | Invalidate/recall command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_node | output | NID_W | Target node |
| cmd_blk | output | BLK_W | Block the command refers to |
| cmd_kind | output | 2 | 0 invalidate, 1 recall-shared, 2 recall-invalidate |
| ack_valid | input | 1 | Acknowledgement or revision valid |
| ack_ready | output | 1 | Acknowledgement accepted |
| ack_rev | input | 1 | 1 = revision carrying data |
| ack_data | input | DATA_W | Revision data |

## Verification
A corrupted presence vector shows at the ports on the next read-exclusive or recall to that block: a command goes to the wrong node, a sharer is skipped, or the command count differs from the number of copies. A wrong acknowledgement count shows as a grant that comes before the last acknowledgement, or a response that never arrives. A stale memory word or a dirty flag left set shows at the next read of the block, through the returned data or through an unexpected recall. The directed scenarios chain transactions on the same block so that each entry update is examined by the very next request.

// File: rtl/fmdir_pkg.sv
package fmdir_pkg;

    typedef enum logic [1:0] {
        CMD_INV        = 2'd0,
        CMD_RECALL_SH  = 2'd1,
        CMD_RECALL_INV = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_REPLY
    } state_e;

    function automatic int unsigned pop64(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int k = 0; k < 64; k++) n += int'(v[k]);
        return n;
    endfunction

endpackage

// File: rtl/fmdir_store.sv
module fmdir_store #(
    parameter int BLOCKS = 8,
    parameter int ENT_W  = 5,
    parameter int DATA_W = 16,
    localparam int BLK_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BLK_W-1:0]  addr,
    output logic [ENT_W-1:0]  rd_ent,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ent_we,
    input  logic [ENT_W-1:0]  ent_wd,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_wd
);
    logic [ENT_W-1:0]  ent_q [BLOCKS];
    logic [DATA_W-1:0] mem_q [BLOCKS];

    assign rd_ent  = ent_q[addr];
    assign rd_data = mem_q[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < BLOCKS; b++) begin
                ent_q[b] <= '0;
                mem_q[b] <= DATA_W'(3 * b + 1);
            end
        end else begin
            if (ent_we) ent_q[addr] <= ent_wd;
            if (mem_we) mem_q[addr] <= mem_wd;
        end
    end
endmodule

// File: rtl/fmdir_first.sv
module fmdir_first #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec[k]) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end
endmodule

// File: rtl/fmdir_top.sv
module fmdir_top #(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16,
    localparam int NID_W = $clog2(NODES),
    localparam int BLK_W = $clog2(BLOCKS),
    localparam int CNT_W = $clog2(NODES + 1),
    localparam int ENT_W = NODES + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NID_W-1:0]  req_node,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic              req_excl,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [NID_W-1:0]  rsp_node,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_excl,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [NID_W-1:0]  cmd_node,
    output logic [BLK_W-1:0]  cmd_blk,
    output logic [1:0]        cmd_kind,
    input  logic              ack_valid,
    output logic              ack_ready,
    input  logic              ack_rev,
    input  logic [DATA_W-1:0] ack_data
);
    import fmdir_pkg::*;

    typedef struct packed {
        logic             dirty;
        logic [NODES-1:0] pres;
    } entry_t;

    state_e           state_q, state_d;
    logic [NID_W-1:0] node_q, node_d;
    logic [BLK_W-1:0] blk_q, blk_d;
    logic             excl_q, excl_d;
    logic             keep_q, keep_d;
    logic [NODES-1:0] tgt_q, tgt_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    cmd_kind_e        kind_q, kind_d;

    logic [BLK_W-1:0]  addr;
    logic [ENT_W-1:0]  rd_raw;
    entry_t            ent, ent_new;
    logic [DATA_W-1:0] rd_data;
    logic              ent_we, mem_we;
    logic [NODES-1:0]  scan_vec, bit_req, bit_cur, tgt_rest;
    logic              scan_found;
    logic [NID_W-1:0]  scan_idx;

    assign addr     = (state_q == ST_IDLE) ? req_blk : blk_q;
    assign ent      = entry_t'(rd_raw);
    assign bit_req  = NODES'(1) << req_node;
    assign bit_cur  = NODES'(1) << node_q;
    assign scan_vec = (state_q == ST_IDLE) ? ent.pres : tgt_q;

    fmdir_store #(.BLOCKS(BLOCKS), .ENT_W(ENT_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .addr(addr),
        .rd_ent(rd_raw), .rd_data(rd_data),
        .ent_we(ent_we), .ent_wd(ENT_W'(ent_new)),
        .mem_we(mem_we), .mem_wd(ack_data)
    );

    fmdir_first #(.N(NODES)) u_first (
        .vec(scan_vec), .found(scan_found), .idx(scan_idx)
    );

    // Handshake outputs
    assign req_ready = (state_q == ST_IDLE);
    assign cmd_valid = (state_q == ST_SEND) && scan_found;
    assign cmd_node  = scan_idx;
    assign cmd_blk   = blk_q;
    assign cmd_kind  = kind_q;
    assign ack_ready = (state_q == ST_SEND) || (state_q == ST_WAIT);
    assign rsp_valid = (state_q == ST_REPLY);
    assign rsp_node  = node_q;
    assign rsp_data  = rd_data;
    assign rsp_excl  = excl_q | keep_q;
    assign mem_we    = ack_valid && ack_ready && ack_rev;
    assign ent_we    = rsp_valid && rsp_ready && !keep_q;
    assign tgt_rest  = tgt_q & ~(NODES'(1) << scan_idx);

    always_comb begin
        ent_new.dirty = excl_q;
        ent_new.pres  = excl_q ? bit_cur : (ent.pres | bit_cur);
    end

    always_comb begin
        state_d = state_q;
        node_d  = node_q;
        blk_d   = blk_q;
        excl_d  = excl_q;
        keep_d  = keep_q;
        tgt_d   = tgt_q;
        cnt_d   = cnt_q;
        kind_d  = kind_q;
        if (ack_valid && ack_ready) cnt_d = cnt_q - CNT_W'(1);
        case (state_q)
            ST_IDLE: if (req_valid) begin
                node_d = req_node;
                blk_d  = req_blk;
                excl_d = req_excl;
                keep_d = 1'b0;
                tgt_d  = '0;
                cnt_d  = '0;
                kind_d = CMD_INV;
                state_d = ST_REPLY;
                if (ent.dirty) begin
                    if (scan_idx == req_node) begin
                        keep_d = 1'b1;
                    end else begin
                        tgt_d   = NODES'(1) << scan_idx;
                        cnt_d   = CNT_W'(1);
                        kind_d  = req_excl ? CMD_RECALL_INV : CMD_RECALL_SH;
                        state_d = ST_SEND;
                    end
                end else if (req_excl) begin
                    tgt_d = ent.pres & ~bit_req;
                    cnt_d = CNT_W'(pop64(64'(ent.pres & ~bit_req)));
                    if ((ent.pres & ~bit_req) != '0) state_d = ST_SEND;
                end
            end
            ST_SEND: if (cmd_valid && cmd_ready) begin
                tgt_d = tgt_rest;
                if (tgt_rest == '0) state_d = ST_WAIT;
            end
            ST_WAIT: if (cnt_q == '0) state_d = ST_REPLY;
            ST_REPLY: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            node_q  <= '0;
            blk_q   <= '0;
            excl_q  <= 1'b0;
            keep_q  <= 1'b0;
            tgt_q   <= '0;
            cnt_q   <= '0;
            kind_q  <= CMD_INV;
        end else begin
            state_q <= state_d;
            node_q  <= node_d;
            blk_q   <= blk_d;
            excl_q  <= excl_d;
            keep_q  <= keep_d;
            tgt_q   <= tgt_d;
            cnt_q   <= cnt_d;
            kind_q  <= kind_d;
        end
    end
endmodule

// File: rtl/fmdir_chk.sv
module fmdir_chk #(
    parameter int NID_W  = 2,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [NID_W-1:0]  rsp_node,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_excl,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [NID_W-1:0]  cmd_node,
    input logic [1:0]        cmd_kind
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!rsp_valid && !cmd_valid && req_ready));

    // R9
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || cmd_valid) |-> !req_ready);

    // R5
    no_grant_with_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cmd_valid);

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_node) && $stable(rsp_data) && $stable(rsp_excl)));

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_node) && $stable(cmd_kind)));

    // R4
    cmd_kind_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_kind != 2'd3));
endmodule

bind fmdir_top fmdir_chk #(.NID_W(NID_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node),
    .rsp_data(rsp_data), .rsp_excl(rsp_excl),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_node(cmd_node),
    .cmd_kind(cmd_kind)
);

// File: tb/sim_fmdir_top.sv
module sim_fmdir_top;
    localparam int CLK_PERIOD = 10;
    localparam int NODES = 4, BLOCKS = 8, DATA_W = 16;
    localparam int NID_W = $clog2(NODES), BLK_W = $clog2(BLOCKS);

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, req_excl = 0;
    logic [NID_W-1:0] req_node = '0;
    logic [BLK_W-1:0] req_blk = '0;
    logic rsp_ready = 1'b1, cmd_ready = 1'b1;
    logic ack_valid = 0, ack_rev = 0;
    logic [DATA_W-1:0] ack_data = '0;
    logic req_ready, rsp_valid, rsp_excl, cmd_valid, ack_ready;
    logic [NID_W-1:0] rsp_node, cmd_node;
    logic [DATA_W-1:0] rsp_data;
    logic [BLK_W-1:0] cmd_blk;
    logic [1:0] cmd_kind;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmdir_top #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u0 (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_req(input int node, input int blk, input bit excl);
        req_node = NID_W'(node); req_blk = BLK_W'(blk); req_excl = excl; req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic expect_cmd(input int node, input int kind, input int blk, input string tag);
        int n = 0;
        while (!cmd_valid && n < 20) begin @(negedge clk); n++; end
        check(cmd_valid, {tag, " cmd present"}, int'(cmd_valid), 1);
        check(int'(cmd_node) == node && int'(cmd_kind) == kind && int'(cmd_blk) == blk,
              {tag, " cmd node/kind/blk"}, int'({cmd_node, cmd_kind, cmd_blk}), (node << 5) | (kind << 3) | blk);
        @(negedge clk);
    endtask

    task automatic send_ack(input bit rev, input int data);
        ack_rev = rev; ack_data = DATA_W'(data); ack_valid = 1;
        while (!ack_ready) @(negedge clk);
        @(negedge clk);
        ack_valid = 0;
    endtask

    task automatic get_rsp(input int node, input int data, input bit excl, input string tag);
        int n = 0;
        bit stray = 0;
        while (!rsp_valid && n < 20) begin
            if (cmd_valid) stray = 1;
            @(negedge clk); n++;
        end
        check(!stray, {tag, " no command"}, int'(stray), 0);
        check(rsp_valid, {tag, " rsp present"}, int'(rsp_valid), 1);
        check(int'(rsp_node) == node && int'(rsp_data) == data && rsp_excl == excl,
              {tag, " rsp node/data/excl"}, int'({rsp_node, rsp_data, rsp_excl}), (node << 17) | (data << 1) | int'(excl));
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(req_ready && !rsp_valid && !cmd_valid, "R1 idle after reset",
              int'({req_ready, rsp_valid, cmd_valid}), 3'b100);
    endtask

    task automatic t_read_clean();
        send_req(1, 2, 0); get_rsp(1, 7, 0, "R2 read clean node1");
        send_req(3, 2, 0); get_rsp(3, 7, 0, "R2 read clean node3");
    endtask

    task automatic t_excl_sharers();
        send_req(1, 2, 1);
        expect_cmd(3, 0, 2, "R4 inval sharer excluding requester");
        repeat (3) @(negedge clk);
        check(!rsp_valid, "R5 no grant before ack", int'(rsp_valid), 0);
        send_ack(0, 0);
        get_rsp(1, 7, 1, "R5 grant after ack");
    endtask

    task automatic t_read_dirty();
        send_req(0, 2, 0);
        expect_cmd(1, 1, 2, "R7 recall from sole owner");
        check(!rsp_valid, "R3 wait for revision", int'(rsp_valid), 0);
        send_ack(1, 16'hBEEF);
        get_rsp(0, 16'hBEEF, 0, "R3 forward revision data");
    endtask

    task automatic t_excl_two();
        send_req(2, 2, 1);
        expect_cmd(0, 0, 2, "R4 inval lowest sharer");
        expect_cmd(1, 0, 2, "R3 former owner kept as sharer");
        send_ack(0, 0);
        check(!rsp_valid, "R5 one ack outstanding", int'(rsp_valid), 0);
        send_ack(0, 0);
        get_rsp(2, 16'hBEEF, 1, "R3 memory updated by revision");
    endtask

    task automatic t_excl_dirty_and_owner();
        send_req(0, 5, 1); get_rsp(0, 16, 1, "R6 grant with no sharers");
        send_req(3, 5, 1);
        expect_cmd(0, 2, 5, "R8 recall-invalidate owner");
        send_ack(1, 16'h1234);
        get_rsp(3, 16'h1234, 1, "R8 grant with revision data");
        send_req(3, 5, 0); get_rsp(3, 16'h1234, 1, "R10 owner request immediate");
        send_req(1, 5, 0);
        expect_cmd(3, 1, 5, "R10 entry unchanged, owner still dirty");
        send_ack(1, 16'h5678);
        get_rsp(1, 16'h5678, 0, "R7 read after owner");
    endtask

    task automatic t_stall();
        send_req(1, 2, 1);
        expect_cmd(2, 2, 2, "R8 recall-invalidate node2");
        req_node = 0; req_blk = 7; req_excl = 0; req_valid = 1;
        repeat (2) @(negedge clk);
        check(!req_ready, "R9 ready low while busy", int'(req_ready), 0);
        send_ack(1, 16'h0042);
        get_rsp(1, 16'h0042, 1, "R9 open transaction completes");
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        get_rsp(0, 22, 0, "R9 stalled request served");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_read_clean();
        t_excl_sharers();
        t_read_dirty();
        t_excl_two();
        t_excl_dirty_and_owner();
        t_stall();
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
        if (!done) check(0, "watchdog expired", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule